// File: doc/BRIEF.md
# Memory-Mapped Probe Register Core

This block sits on a simple synchronous register bus and gives a host a window onto a small set of hardware signals. Two input probes are sampled into snapshot buffers, and two output probes are driven from registers that the host stages in advance. Every access is a 16-bit word. A probe wider than one word is spread over consecutive addresses, lowest bits first.

Snapshots and output updates never track the live signals. They happen together, and only when the host raises a strobe bit at the core's base address. The host first stages output values and then pulses the strobe by writing 1 and then 0. In the cycle the strobe goes from 0 to 1, every input snapshot is taken and every output port takes its staged value. It then reads the captured inputs at leisure.

The bus is registered through the core with one cycle of delay. The core answers reads inside its own address window. Every other transaction leaves the core unchanged, so several cores can be chained on one bus.

Top module: `probe_core`

## Requirements
- R1: The strobe bit lives at `BASE_ADDR`. Input probe A starts at `BASE_ADDR+1`. Each probe takes ceil(width/16) addresses. Probes are allocated with no gaps in this order: input A, input B, output A, output B. With the defaults (base 0x10) the map is: strobe 0x10, inA 0x11, inB 0x12–0x13, outA 0x14, outB 0x15–0x16.
- R2: Word k of a probe holds bits 16k+15..16k. In the top word, bits above the probe width read as zero.
- R3: `busAddrOut`, `busRwOut` and `busValidOut` are copies of the bus inputs delayed by one cycle. For an in-window read, `busDataOut` carries the addressed word one cycle after the request. For every other transaction it carries the delayed `busDataIn`.
- R4: A write to an output probe word updates only that word of the staging buffer. The output port does not change until the next strobe rise. Staging buffers read back what was written.
- R5: A write to an input probe address changes nothing that is readable.
- R6: After reset, input snapshots read zero. Output staging buffers and output ports hold their parameterised initial values (defaults 1 and 0x123456). The strobe reads 0.
- R7: A write of bit0=1 to the strobe while it holds 0 triggers the capture. In that clock edge, both inputs are loaded into their snapshots and both output ports take their staging values. A write of 1 while the strobe already holds 1 triggers nothing. At all other times, snapshots and ports hold their values.
- R8: The strobe stores bit 0 of the written data. It reads back as 0x0000 or 0x0001.
- R9: A transaction below `BASE_ADDR` or above the last probe address has no read or write effect and passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Request address |
| busDataIn | input | 16 | Write data, or pass-through data |
| busRw | input | 1 | 1 = write, 0 = read |
| busValid | input | 1 | Request valid |
| busAddrOut | output | ADDR_W | Delayed address |
| busDataOut | output | 16 | Read data, or delayed data |
| busRwOut | output | 1 | Delayed direction |
| busValidOut | output | 1 | Delayed valid |
| inA | input | IN_A_W | Input probe A |
| inB | input | IN_B_W | Input probe B |
| outA | output | OUT_A_W | Output probe A |
| outB | output | OUT_B_W | Output probe B |

## Verification
The assertions assume that bus fields are meaningful only while `busValid` is high. They also assume a strobe capture can come only from a valid write of bit0=1 to `BASE_ADDR`. The bench keeps to this:
- It drives exactly one transaction per two cycles and deasserts `busValid` in between.
- It changes the probe inputs only on falling edges and only while the bus is idle.
- It sends every strobe change as a single write.

// File: rtl/probe_core_pkg.sv
package probe_core_pkg;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 4;

  function automatic int nWords(input int width);
    return (width + WORD_W - 1) / WORD_W;
  endfunction

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STROBE, SEL_IN_A, SEL_IN_B, SEL_OUT_A, SEL_OUT_B
  } probe_sel_e;

  typedef struct packed {
    probe_sel_e       sel;
    logic [IDX_W-1:0] wordIdx;
    logic             doWrite;
    logic             doRead;
    logic             capture;
    logic             strobeVal;
  } probe_ctl_t;
endpackage

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import probe_core_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0010,
  parameter int IN_A_W = 1,
  parameter int IN_B_W = 20,
  parameter int OUT_A_W = 1,
  parameter int OUT_B_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busDataIn,
  input  logic              busRw,
  input  logic              busValid,
  output probe_ctl_t        ctl
);
  localparam int IA_OFF = 1;
  localparam int IB_OFF = IA_OFF + nWords(IN_A_W);
  localparam int OA_OFF = IB_OFF + nWords(IN_B_W);
  localparam int OB_OFF = OA_OFF + nWords(OUT_A_W);
  localparam int LAST_OFF = OB_OFF + nWords(OUT_B_W) - 1;

  logic [ADDR_W-1:0] offset;
  logic inRange;
  logic strobeQ;
  probe_sel_e sel;
  logic [IDX_W-1:0] wordIdx;

  assign offset  = busAddr - BASE_ADDR;
  assign inRange = (busAddr >= BASE_ADDR) && (offset <= ADDR_W'(LAST_OFF));

  always_comb begin
    sel = SEL_NONE;
    wordIdx = '0;
    if (inRange) begin
      if (offset == '0) begin
        sel = SEL_STROBE;
      end else if (offset < ADDR_W'(IB_OFF)) begin
        sel = SEL_IN_A;
        wordIdx = IDX_W'(offset - ADDR_W'(IA_OFF));
      end else if (offset < ADDR_W'(OA_OFF)) begin
        sel = SEL_IN_B;
        wordIdx = IDX_W'(offset - ADDR_W'(IB_OFF));
      end else if (offset < ADDR_W'(OB_OFF)) begin
        sel = SEL_OUT_A;
        wordIdx = IDX_W'(offset - ADDR_W'(OA_OFF));
      end else begin
        sel = SEL_OUT_B;
        wordIdx = IDX_W'(offset - ADDR_W'(OB_OFF));
      end
    end
  end

  logic strobeWr;
  assign strobeWr = busValid && busRw && (sel == SEL_STROBE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeQ <= 1'b0;
    else if (strobeWr) strobeQ <= busDataIn[0];
  end

  always_comb begin
    ctl.sel       = sel;
    ctl.wordIdx   = wordIdx;
    ctl.doWrite   = busValid && busRw && inRange;
    ctl.doRead    = busValid && !busRw && inRange;
    ctl.capture   = strobeWr && busDataIn[0] && !strobeQ;
    ctl.strobeVal = strobeQ;
  end
endmodule

// File: rtl/probe_dpath.sv
module probe_dpath
  import probe_core_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IN_A_W = 1,
  parameter int IN_B_W = 20,
  parameter int OUT_A_W = 1,
  parameter int OUT_B_W = 24,
  parameter logic [OUT_A_W-1:0] OUT_A_INIT = 1'b1,
  parameter logic [OUT_B_W-1:0] OUT_B_INIT = 24'h123456
) (
  input  logic               clk,
  input  logic               rstN,
  input  probe_ctl_t         ctl,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [WORD_W-1:0]  busDataIn,
  input  logic               busRw,
  input  logic               busValid,
  output logic [ADDR_W-1:0]  busAddrOut,
  output logic [WORD_W-1:0]  busDataOut,
  output logic               busRwOut,
  output logic               busValidOut,
  input  logic [IN_A_W-1:0]  inA,
  input  logic [IN_B_W-1:0]  inB,
  output logic [OUT_A_W-1:0] outA,
  output logic [OUT_B_W-1:0] outB
);
  localparam int IA_PAD = nWords(IN_A_W) * WORD_W;
  localparam int IB_PAD = nWords(IN_B_W) * WORD_W;
  localparam int OA_PAD = nWords(OUT_A_W) * WORD_W;
  localparam int OB_PAD = nWords(OUT_B_W) * WORD_W;

  logic [IN_A_W-1:0]  inABuf;
  logic [IN_B_W-1:0]  inBBuf;
  logic [OUT_A_W-1:0] outABuf, outANext;
  logic [OUT_B_W-1:0] outBBuf, outBNext;
  logic [IA_PAD-1:0] iaPad;
  logic [IB_PAD-1:0] ibPad;
  logic [OA_PAD-1:0] oaPad, oaIns;
  logic [OB_PAD-1:0] obPad, obIns;
  logic [WORD_W-1:0] rdWord;
  logic [IDX_W+4-1:0] bitPos;

  assign bitPos = {ctl.wordIdx, 4'b0000};
  assign iaPad = IA_PAD'(inABuf);
  assign ibPad = IB_PAD'(inBBuf);
  assign oaPad = OA_PAD'(outABuf);
  assign obPad = OB_PAD'(outBBuf);

  always_comb begin
    oaIns = oaPad;
    oaIns[bitPos +: WORD_W] = busDataIn;
    obIns = obPad;
    obIns[bitPos +: WORD_W] = busDataIn;
    outANext = OUT_A_W'(oaIns);
    outBNext = OUT_B_W'(obIns);
  end

  always_comb begin
    case (ctl.sel)
      SEL_STROBE: rdWord = {{(WORD_W-1){1'b0}}, ctl.strobeVal};
      SEL_IN_A:   rdWord = iaPad[bitPos +: WORD_W];
      SEL_IN_B:   rdWord = ibPad[bitPos +: WORD_W];
      SEL_OUT_A:  rdWord = oaPad[bitPos +: WORD_W];
      SEL_OUT_B:  rdWord = obPad[bitPos +: WORD_W];
      default:    rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inABuf  <= '0;
      inBBuf  <= '0;
      outABuf <= OUT_A_INIT;
      outBBuf <= OUT_B_INIT;
      outA    <= OUT_A_INIT;
      outB    <= OUT_B_INIT;
    end else begin
      if (ctl.doWrite && ctl.sel == SEL_OUT_A) outABuf <= outANext;
      if (ctl.doWrite && ctl.sel == SEL_OUT_B) outBBuf <= outBNext;
      if (ctl.capture) begin
        inABuf <= inA;
        inBBuf <= inB;
        outA   <= outABuf;
        outB   <= outBBuf;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddrOut  <= '0;
      busDataOut  <= '0;
      busRwOut    <= 1'b0;
      busValidOut <= 1'b0;
    end else begin
      busAddrOut  <= busAddr;
      busRwOut    <= busRw;
      busValidOut <= busValid;
      busDataOut  <= ctl.doRead ? rdWord : busDataIn;
    end
  end
endmodule

// File: rtl/probe_core.sv
module probe_core
  import probe_core_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0010,
  parameter int IN_A_W = 1,
  parameter int IN_B_W = 20,
  parameter int OUT_A_W = 1,
  parameter int OUT_B_W = 24,
  parameter logic [OUT_A_W-1:0] OUT_A_INIT = 1'b1,
  parameter logic [OUT_B_W-1:0] OUT_B_INIT = 24'h123456
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [15:0]        busDataIn,
  input  logic               busRw,
  input  logic               busValid,
  output logic [ADDR_W-1:0]  busAddrOut,
  output logic [15:0]        busDataOut,
  output logic               busRwOut,
  output logic               busValidOut,
  input  logic [IN_A_W-1:0]  inA,
  input  logic [IN_B_W-1:0]  inB,
  output logic [OUT_A_W-1:0] outA,
  output logic [OUT_B_W-1:0] outB
);
  probe_ctl_t ctl;

  probe_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .IN_A_W(IN_A_W), .IN_B_W(IN_B_W), .OUT_A_W(OUT_A_W), .OUT_B_W(OUT_B_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busDataIn(busDataIn),
    .busRw(busRw), .busValid(busValid), .ctl(ctl)
  );

  probe_dpath #(
    .ADDR_W(ADDR_W), .IN_A_W(IN_A_W), .IN_B_W(IN_B_W),
    .OUT_A_W(OUT_A_W), .OUT_B_W(OUT_B_W),
    .OUT_A_INIT(OUT_A_INIT), .OUT_B_INIT(OUT_B_INIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .busAddr(busAddr), .busDataIn(busDataIn), .busRw(busRw), .busValid(busValid),
    .busAddrOut(busAddrOut), .busDataOut(busDataOut),
    .busRwOut(busRwOut), .busValidOut(busValidOut),
    .inA(inA), .inB(inB), .outA(outA), .outB(outB)
  );
endmodule

// File: rtl/probe_core_chk.sv
module probe_core_chk
  import probe_core_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0010,
  parameter int IN_A_W = 1,
  parameter int IN_B_W = 20,
  parameter int OUT_A_W = 1,
  parameter int OUT_B_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [15:0]        busDataIn,
  input logic               busRw,
  input logic               busValid,
  input logic [ADDR_W-1:0]  busAddrOut,
  input logic [15:0]        busDataOut,
  input logic               busRwOut,
  input logic               busValidOut,
  input logic [OUT_A_W-1:0] outA,
  input logic [OUT_B_W-1:0] outB
);
  localparam int SPAN = nWords(IN_A_W) + nWords(IN_B_W) + nWords(OUT_A_W) + nWords(OUT_B_W);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(SPAN);

  logic outside;
  assign outside = (busAddr < BASE_ADDR) || (busAddr > LAST_ADDR);

  AST_PASS_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> busValidOut && busAddrOut == $past(busAddr) && busRwOut == $past(busRw)) else $error("AST_PASS_CTRL"); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !busValidOut) else $error("AST_IDLE_QUIET"); // R3
  AST_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busRw) |=> busDataOut == $past(busDataIn)) else $error("AST_WRITE_ECHO"); // R3
  AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && outside) |=> busDataOut == $past(busDataIn)) else $error("AST_OUTSIDE_PASS"); // R9
  AST_PORTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busRw && busAddr == BASE_ADDR && busDataIn[0]) |=> $stable(outA) && $stable(outB)) else $error("AST_PORTS_HOLD"); // R7
endmodule

bind probe_core probe_core_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
  .IN_A_W(IN_A_W), .IN_B_W(IN_B_W), .OUT_A_W(OUT_A_W), .OUT_B_W(OUT_B_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busDataIn(busDataIn),
  .busRw(busRw), .busValid(busValid), .busAddrOut(busAddrOut),
  .busDataOut(busDataOut), .busRwOut(busRwOut), .busValidOut(busValidOut),
  .outA(outA), .outB(outB)
);

// File: tb/probe_core_tb.sv
module probe_core_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [15:0] busDataIn = '0;
  logic busRw = 1'b0;
  logic busValid = 1'b0;
  logic [15:0] busAddrOut;
  logic [15:0] busDataOut;
  logic busRwOut, busValidOut;
  logic inA = 1'b0;
  logic [19:0] inB = '0;
  logic outA;
  logic [23:0] outB;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] expData[$];
  logic [15:0] expAddr[$];
  string expReq[$];

  always #10 clk = ~clk;

  probe_core u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busDataIn(busDataIn),
    .busRw(busRw), .busValid(busValid), .busAddrOut(busAddrOut),
    .busDataOut(busDataOut), .busRwOut(busRwOut), .busValidOut(busValidOut),
    .inA(inA), .inB(inB), .outA(outA), .outB(outB)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one transaction, valid for one rising edge
  task automatic busOp(input logic [15:0] addr, input logic rw, input logic [15:0] data);
    @(negedge clk);
    busAddr = addr; busRw = rw; busDataIn = data; busValid = 1'b1;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] addr, input logic [15:0] exp, input string req);
    expData.push_back(exp); expAddr.push_back(addr); expReq.push_back(req);
    busOp(addr, 1'b0, 16'h0000);
  endtask

  task automatic rdPass(input logic [15:0] addr, input logic [15:0] data, input string req);
    expData.push_back(data); expAddr.push_back(addr); expReq.push_back(req);
    busOp(addr, 1'b0, data);
  endtask

  task automatic wr(input logic [15:0] addr, input logic [15:0] data);
    busOp(addr, 1'b1, data);
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rstN && busValidOut && !busRwOut) begin
      if (expData.size() == 0) begin
        check("R3 unexpected read", 32'(busDataOut), 32'hFFFF_FFFF);
      end else begin
        logic [15:0] d, a;
        string r;
        d = expData.pop_front(); a = expAddr.pop_front(); r = expReq.pop_front();
        check(r, 32'(busDataOut), 32'(d));
        check("R3 addr pass", 32'(busAddrOut), 32'(a));
      end
    end
  end

  initial begin
    #(20 * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 outA reset", 32'(outA), 32'h1);
    check("R6 outB reset", 32'(outB), 32'h123456);
    check("R3 idle valid", 32'(busValidOut), 32'h0);
    rd(16'h0010, 16'h0000, "R6 R8 strobe reset");
    rd(16'h0011, 16'h0000, "R6 inA reset");
    rd(16'h0012, 16'h0000, "R6 inB lo reset");
    rd(16'h0013, 16'h0000, "R6 inB hi reset");
    rd(16'h0014, 16'h0001, "R1 R6 outA stage init");
    rd(16'h0015, 16'h3456, "R2 outB lo init");
    rd(16'h0016, 16'h0012, "R2 outB hi init");

    // live inputs change, no strobe yet
    inA = 1'b1; inB = 20'hABCDE;
    rd(16'h0012, 16'h0000, "R7 no capture without strobe");
    wr(16'h0015, 16'hBEEF);
    wr(16'h0016, 16'hFF77);
    wr(16'h0014, 16'h0000);
    rd(16'h0015, 16'hBEEF, "R4 outB lo staged");
    rd(16'h0016, 16'h0077, "R2 R4 outB hi truncated");
    rd(16'h0014, 16'h0000, "R4 outA staged");
    check("R4 outB port unchanged", 32'(outB), 32'h123456);
    check("R4 outA port unchanged", 32'(outA), 32'h1);
    wr(16'h0012, 16'h5555);
    wr(16'h0011, 16'h0001);
    rd(16'h0012, 16'h0000, "R5 input write ignored lo");
    rd(16'h0011, 16'h0000, "R5 input write ignored A");

    // strobe rise
    wr(16'h0010, 16'h0001);
    check("R7 outB updated", 32'(outB), 32'h77BEEF);
    check("R7 outA updated", 32'(outA), 32'h0);
    rd(16'h0010, 16'h0001, "R8 strobe reads 1");
    rd(16'h0011, 16'h0001, "R7 inA captured");
    rd(16'h0012, 16'hBCDE, "R2 R7 inB lo captured");
    rd(16'h0013, 16'h000A, "R2 R7 inB hi captured");

    // writing 1 again while high does not recapture
    inB = 20'h12345;
    wr(16'h0010, 16'hFFFF);
    rd(16'h0012, 16'hBCDE, "R7 no recapture when held");
    wr(16'h0010, 16'h0000);
    rd(16'h0010, 16'h0000, "R8 strobe reads 0");
    rd(16'h0012, 16'hBCDE, "R7 fall does not capture");
    wr(16'h0015, 16'h0042);
    wr(16'h0010, 16'h0001);
    check("R7 outB second update", 32'(outB), 32'h770042);
    rd(16'h0012, 16'h2345, "R7 inB lo recaptured");
    rd(16'h0013, 16'h0001, "R7 inB hi recaptured");
    wr(16'h0010, 16'h0000);

    // outside the window
    rdPass(16'h0017, 16'h9999, "R9 read above window");
    rdPass(16'h000F, 16'h4321, "R9 read below window");
    wr(16'h000F, 16'h0001);
    wr(16'h0017, 16'h0000);
    rd(16'h0010, 16'h0000, "R9 strobe untouched");
    rd(16'h0015, 16'h0042, "R9 outB stage untouched");
    check("R9 outB port untouched", 32'(outB), 32'h770042);

    repeat (3) @(negedge clk);
    check("R3 queue drained", 32'(expData.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule